// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This unit sits next to a 32-bit integer pipeline and performs integer multiplication and division one bit per clock. It keeps two internal result registers, HI and LO. A multiply leaves the 64-bit product split across them, with the upper half in HI. A divide leaves the quotient in LO and the remainder in HI. The pipeline can also write either register from operand A and can choose which one appears on the result port. That port feeds the pipeline's second ALU operand.

Each command is a single-cycle 4-bit word. Bit 3 marks the word as valid. Any valid word starts at once and abandons whatever operation is still running. While a multiply or divide is in progress, the busy output asks the pipeline to stall.

Top module: `muldiv_unit`

## Requirements
- R1: While rst is high at a clock edge, HI, LO, the step counter and busy are cleared and the result port is set to show HI. After reset, busy is 0 and result is 0.
- R2: A command with bit 3 clear (for example 0000 or 0111) is ignored. It changes neither HI, LO, the result selection nor busy, and it does not stop a running operation.
- R3: Command 1001 writes op_a into HI and command 1011 writes op_a into LO, in one cycle. Neither raises busy.
- R4: Command 1000 selects HI and command 1010 selects LO for the result port. The port shows the selected register from the cycle after the command, and the selection lasts until the next read command.
- R5: Command 1101 (unsigned multiply) leaves the unsigned 64-bit product of op_a and op_b in {HI, LO}.
- R6: Command 1100 (signed multiply) leaves the two's-complement 64-bit product in {HI, LO}.
- R7: Command 1111 (unsigned divide) leaves op_a / op_b in LO and op_a % op_b in HI.
- R8: Command 1110 (signed divide) rounds the quotient toward zero. The quotient is negative when the operand signs differ, and the remainder carries the sign of op_a.
- R9: After a multiply or divide command, busy is high for exactly 32 cycles, starting in the cycle after the command. The new HI and LO can be read as soon as busy falls.
- R10: A valid command issued while busy is high abandons the running operation. The abandoned operation never writes HI or LO. If the new command is a multiply or divide, it runs for the full 32 cycles.
- R11: A divide by zero finishes in the normal 32 cycles and then drops busy. The values it leaves in HI and LO are not specified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand: multiplicand, dividend, or data for a HI/LO write |
| op_b | input | 32 | Second operand: multiplier or divisor |
| cmd | input | 4 | One-cycle command: bit 3 valid, bit 2 arithmetic, bits 1..0 select |
| result | output | 32 | HI or LO, chosen by the most recent read command |
| busy | output | 1 | High while a multiply or divide is running |

## Verification
The bench uses operands that push the sign handling to its edges. These include all-ones unsigned factors, the largest positive value times the most negative value, and every sign mix in signed division. A unit that fixed up the signs wrongly would return an inverted product, or a remainder with the divisor's sign. The bench also interrupts a running multiply with a read command and with a second operation. A unit that let the abandoned operation finish would overwrite HI and LO, or would shorten the second operation's busy time. Separate checks confirm that a divide by zero still clears busy after 32 cycles, and that a word with bit 3 clear but other bits set leaves every register alone.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // command word layout: {valid, arith, sel[1:0]}
  typedef struct packed {
    logic       valid;
    logic       arith;
    logic [1:0] sel;
  } cmd_t;

  // sel meanings when arith is clear
  typedef enum logic [1:0] {
    XF_RD_HI = 2'b00,
    XF_WR_HI = 2'b01,
    XF_RD_LO = 2'b10,
    XF_WR_LO = 2'b11
  } xfer_e;

  // sel bit 0 = unsigned, bit 1 = divide when arith is set
  localparam int unsigned SEL_UNSIGNED_BIT = 0;
  localparam int unsigned SEL_DIVIDE_BIT   = 1;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         is_signed,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_rem
);

  logic [1:0][W-1:0] ops;
  logic [1:0][W-1:0] mags;
  logic [1:0]        negs;

  assign ops = {op_b, op_a};

  // absolute value of each operand when the operation is signed
  for (genvar i = 0; i < 2; i++) begin : g_abs
    assign negs[i] = is_signed & ops[i][W-1];
    assign mags[i] = negs[i] ? (~ops[i] + 1'b1) : ops[i];
  end

  assign mag_a    = mags[0];
  assign mag_b    = mags[1];
  assign neg_main = negs[0] ^ negs[1];
  assign neg_rem  = negs[0];

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         kill,
  input  logic         is_div,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);

  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned WW    = 2 * W;

  logic [WW-1:0]    work_q;
  logic [W-1:0]     opnd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, div_q, negm_q, negr_q;

  logic [W:0]       sum, rem_sh, diff;
  logic [WW-1:0]    mul_next, div_next, nxt, prod_fix;

  // shift-and-add step: add the multiplicand when the low bit is set, shift right
  always_comb begin
    sum      = {1'b0, work_q[WW-1:W]} + (work_q[0] ? {1'b0, opnd_q} : '0);
    mul_next = {sum, work_q[W-1:1]};
  end

  // restoring step: shift the next dividend bit into the remainder and try a subtract
  always_comb begin
    rem_sh = {work_q[WW-1:W], work_q[W-1]};
    diff   = rem_sh - {1'b0, opnd_q};
    if (diff[W])
      div_next = {rem_sh[W-1:0], work_q[W-2:0], 1'b0};
    else
      div_next = {diff[W-1:0], work_q[W-2:0], 1'b1};
  end

  assign nxt      = div_q ? div_next : mul_next;
  assign prod_fix = negm_q ? (~nxt + 1'b1) : nxt;

  always_comb begin
    if (div_q) begin
      res_lo = negm_q ? (~nxt[W-1:0] + 1'b1) : nxt[W-1:0];
      res_hi = negr_q ? (~nxt[WW-1:W] + 1'b1) : nxt[WW-1:W];
    end else begin
      res_lo = prod_fix[W-1:0];
      res_hi = prod_fix[WW-1:W];
    end
  end

  assign done = busy_q && (cnt_q == CNT_W'(1));
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      opnd_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      negm_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (start) begin
      work_q <= {{W{1'b0}}, mag_a};
      opnd_q <= mag_b;
      cnt_q  <= CNT_W'(W);
      busy_q <= 1'b1;
      div_q  <= is_div;
      negm_q <= neg_main;
      negr_q <= neg_rem;
    end else if (kill) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      work_q <= nxt;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1))
        busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   cmd,
  output logic [W-1:0] result,
  output logic         busy
);
  import muldiv_pkg::*;

  cmd_t         c;
  logic         xfer, start;
  logic [W-1:0] mag_a, mag_b;
  logic         neg_main, neg_rem, done;
  logic [W-1:0] res_hi, res_lo;
  logic [W-1:0] hi_q, lo_q, hi_n, lo_n, result_q;
  logic         rd_lo_q, rd_lo_n;

  assign c     = cmd_t'(cmd);
  assign xfer  = c.valid & ~c.arith;
  assign start = c.valid &  c.arith;

  muldiv_prep #(.W(W)) u_prep (
    .op_a      (op_a),
    .op_b      (op_b),
    .is_signed (~c.sel[SEL_UNSIGNED_BIT]),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_main  (neg_main),
    .neg_rem   (neg_rem)
  );

  muldiv_engine #(.W(W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .kill     (c.valid),
    .is_div   (c.sel[SEL_DIVIDE_BIT]),
    .neg_main (neg_main),
    .neg_rem  (neg_rem),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .busy     (busy),
    .done     (done),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  // a new valid command always takes priority over a completing operation
  always_comb begin
    hi_n    = hi_q;
    lo_n    = lo_q;
    rd_lo_n = rd_lo_q;
    if (xfer) begin
      case (xfer_e'(c.sel))
        XF_RD_HI: rd_lo_n = 1'b0;
        XF_WR_HI: hi_n    = op_a;
        XF_RD_LO: rd_lo_n = 1'b1;
        XF_WR_LO: lo_n    = op_a;
        default:  ;
      endcase
    end else if (done && !c.valid) begin
      hi_n = res_hi;
      lo_n = res_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      rd_lo_q  <= 1'b0;
      result_q <= '0;
    end else begin
      hi_q     <= hi_n;
      lo_q     <= lo_n;
      rd_lo_q  <= rd_lo_n;
      result_q <= rd_lo_n ? lo_n : hi_n;
    end
  end

  assign result = result_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   cmd,
  input logic [W-1:0] result,
  input logic         busy
);

  localparam int unsigned RC_W = $clog2(W) + 2;

  logic [RC_W-1:0] run_cnt;
  logic            go;

  assign go = cmd[3] && cmd[2];

  // counts busy cycles since the latest multiply/divide command
  always_ff @(posedge clk) begin
    if (rst)
      run_cnt <= '0;
    else if (go)
      run_cnt <= '0;
    else if (busy)
      run_cnt <= run_cnt + 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!busy && result == '0)); // R1

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cmd[3] && !busy) |=> ($stable(result) && !busy)); // R2

  AST_XFER_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd[3] && !cmd[2]) |=> !busy); // R3

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    go |=> busy); // R9

  AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go)); // R9

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < RC_W'(W))); // R9

  AST_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(cmd[3])) |-> (run_cnt == RC_W'(W))); // R11

  AST_HOLD_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (busy && !cmd[3] && run_cnt < RC_W'(W - 1)) |=> $stable(result)); // R10

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cmd    (cmd),
  .result (result),
  .busy   (busy)
);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   cmd = 4'b0000;
  logic [W-1:0] result;
  logic         busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t exp_q[$];

  always #10 clk = ~clk;

  muldiv_unit #(.W(W)) uut (
    .clk    (clk),
    .rst    (rst),
    .op_a   (op_a),
    .op_b   (op_b),
    .cmd    (cmd),
    .result (result),
    .busy   (busy)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: compares queued expectations with the result port
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      chk(result, it.exp, it.tag);
    end
  end

  task automatic issue(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    cmd  = c;
    op_a = a;
    op_b = b;
    @(posedge clk);
    #1 cmd = 4'b0000;
  endtask

  task automatic read_exp(input bit lo, input logic [W-1:0] exp, input string tag);
    issue(lo ? 4'b1010 : 4'b1000, '0, '0);
    exp_q.push_back('{exp, tag});
  endtask

  task automatic count_busy(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] ehi, input logic [W-1:0] elo, input string tag);
    int n;
    issue(c, a, b);
    count_busy(n);
    chk(n, 32, {tag, " busy length R9"});
    read_exp(0, ehi, {tag, " HI"});
    read_exp(1, elo, {tag, " LO"});
  endtask

  task automatic mul_u(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [63:0] p;
    p = {32'b0, a} * {32'b0, b};
    run_op(4'b1101, a, b, p[63:32], p[31:0], tag);
  endtask

  task automatic mul_s(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    run_op(4'b1100, a, b, p[63:32], p[31:0], tag);
  endtask

  task automatic div_u(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    run_op(4'b1111, a, b, a % b, a / b, tag);
  endtask

  task automatic div_s(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic signed [W-1:0] q, r;
    q = $signed(a) / $signed(b);
    r = $signed(a) % $signed(b);
    run_op(4'b1110, a, b, r, q, tag);
  endtask

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy, 0, "R1 busy after reset");
    chk(result, 0, "R1 result after reset");

    // R3, R4: register writes and read selection
    issue(4'b1001, 32'h1234_5678, 32'hdead_beef);
    chk(busy, 0, "R3 write HI no busy");
    issue(4'b1011, 32'h9abc_def0, '0);
    chk(busy, 0, "R3 write LO no busy");
    read_exp(0, 32'h1234_5678, "R3 R4 read HI");
    read_exp(1, 32'h9abc_def0, "R3 R4 read LO");
    repeat (3) @(negedge clk);
    chk(result, 32'h9abc_def0, "R4 selection persists");

    // R2: commands with bit 3 clear are ignored
    issue(4'b0111, 32'hffff_ffff, 32'hffff_ffff);
    issue(4'b0101, 32'h0bad_0bad, 32'h1);
    chk(busy, 0, "R2 no busy from bit3-clear word");
    chk(result, 32'h9abc_def0, "R2 LO untouched");
    read_exp(0, 32'h1234_5678, "R2 HI untouched");

    // R5 unsigned multiply
    mul_u(32'hffff_ffff, 32'hffff_ffff, "R5 all ones");
    mul_u(32'h1234_5678, 32'h9abc_def0, "R5 mixed");
    mul_u(32'h0, 32'h5555_aaaa, "R5 zero");
    // R6 signed multiply
    mul_s(-32'sd3, 32'sd7, "R6 neg*pos");
    mul_s(-32'sd5, -32'sd9, "R6 neg*neg");
    mul_s(32'h7fff_ffff, 32'h8000_0000, "R6 max*min");
    // R7 unsigned divide
    div_u(32'd100, 32'd7, "R7 small");
    div_u(32'hffff_ffff, 32'd3, "R7 large");
    div_u(32'd5, 32'd10, "R7 below divisor");
    // R8 signed divide
    div_s(-32'sd100, 32'sd7, "R8 neg/pos");
    div_s(32'sd100, -32'sd7, "R8 pos/neg");
    div_s(-32'sd100, -32'sd7, "R8 neg/neg");

    // R11 divide by zero completes
    issue(4'b1111, 32'd77, 32'd0);
    count_busy(n);
    chk(n, 32, "R11 div by zero busy length");
    chk(busy, 0, "R11 busy released");

    // R10 abort by a write, abandoned op must not touch HI/LO
    issue(4'b1001, 32'haaaa_0001, '0);
    issue(4'b1011, 32'hbbbb_0002, '0);
    issue(4'b1101, 32'hffff_ffff, 32'hffff_ffff);
    repeat (4) @(negedge clk);
    chk(busy, 1, "R10 running before abort");
    read_exp(1, 32'hbbbb_0002, "R10 abort read LO");
    @(negedge clk);
    chk(busy, 0, "R10 busy cleared by abort");
    repeat (40) @(negedge clk);
    chk(result, 32'hbbbb_0002, "R10 LO kept after abort");
    read_exp(0, 32'haaaa_0001, "R10 HI kept after abort");

    // R10 abort by a new operation: second one runs in full
    issue(4'b1111, 32'd1000, 32'd3);
    repeat (9) @(negedge clk);
    issue(4'b1101, 32'd6, 32'd7);
    count_busy(n);
    chk(n, 32, "R10 restarted op busy length");
    read_exp(1, 32'd42, "R10 restarted product LO");
    read_exp(0, 32'd0, "R10 restarted product HI");

    repeat (3) @(negedge clk);
    summary();
  end

endmodule